// File: doc/BRIEF.md
# Headphone Playback Power Sequencer

This block brings an audio codec's headphone playback path up and down by issuing a fixed, ordered list of register writes. Each write goes out on a request/acknowledge port that carries an 8-bit register address and 8-bit data. Some steps need analog or clock settling before the next write can follow. At those steps the block holds off for a programmed number of ticks. A clock-enable prescaler produces the ticks, so every wait is a multiple of `PRESCALE` clock cycles.

A one-cycle `startCmd` pulse runs the power-up list and ends in the playing state. A one-cycle `stopCmd` pulse runs the power-down list and ends in idle. The amplifier supply bits are only cleared after the headphone common voltage has had two full fall-time constants to discharge. This holds even when the stop arrives while the common voltage is still rising.

The encoding used throughout is a write of data D to address A, written A<-D, in hexadecimal.

Top module: `hp_power_seq`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the block is forced to idle: `idle`=1, `busy`=0, `playing`=0 and `wrReq`=0 from the next cycle.
- R2: A start in idle issues these writes, strictly in this order: 01<-F4, 08<-A5, 18<-0A, 1A<-28, 1B<-28, 0B<-01, 0C<-01, 00<-C1, 10<-63, 10<-67.
- R3: `wrReq` stays high, with `wrAddr` and `wrData` unchanged, until the edge that samples `wrAck` high. No second write is outstanding, and `wrReq` is low in idle, in playing and during every wait.
- R4: With `PLL_MODE`=1, the request for 08<-A5 rises LOCK_TICKS*PRESCALE+1 cycles after the edge that accepted 01<-F4. With `PLL_MODE`=0 it rises in the cycle right after that edge.
- R5: The request following 00<-C1 rises SETTLE_TICKS*PRESCALE+1 cycles after the edge that accepted 00<-C1. Writes without a wait are requested in the cycle right after the previous acceptance.
- R6: `playing` rises RISE_TICKS*PRESCALE+1 cycles after 10<-67 is accepted. It then stays high until a stop is sampled.
- R7: A stop while playing issues these writes, in this order: 10<-63, 10<-00, 00<-01, 18<-02, 0B<-00, 0C<-00.
- R8: The request for 10<-00 rises no earlier than 2*FALL_TICKS*PRESCALE+1 cycles after the edge that accepted the preceding 10<-63.
- R9: A stop sampled during the rise wait ends that wait at once and starts the R7 list, including the full R8 fall wait.
- R10: A start is ignored unless the block is idle. A stop is ignored unless the block is playing or in the rise wait. An ignored command changes neither the status outputs nor the write stream.
- R11: Exactly one of `idle`, `busy` and `playing` is high. `busy` is high from the cycle after a start is accepted until the last write of a list completes.
- R12: In the cycle after 0C<-00 is accepted, `idle` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startCmd | input | 1 | Start-playback command, sampled on the clock edge |
| stopCmd | input | 1 | Stop-playback command, sampled on the clock edge |
| wrReq | output | 1 | Register write request |
| wrAddr | output | 8 | Register address of the pending write |
| wrData | output | 8 | Data of the pending write |
| wrAck | input | 1 | Write accepted; completes the write when sampled with `wrReq` high |
| busy | output | 1 | A write list is in progress |
| playing | output | 1 | Playback path is fully up |
| idle | output | 1 | Path is down and the block accepts a start |

## Verification
All outputs come from registers.

| Event | When the result is due |
|---|---|
| Accepted command or accepted write without a wait | The next write request, or the new status, one clock edge later |
| Accepted write followed by a wait of T ticks | The next request appears T*PRESCALE+1 edges after the accepting edge |

The reference model in the bench advances on the same edges using integer countdowns and a queue of pending writes and waits. Every output is compared against it at the falling edge, half a cycle after each update. This catches an early or late request, a request that drifts before it is acknowledged, and a wrong address or data value in the exact cycle it appears.

// File: rtl/hp_seq_pkg.sv
package hp_seq_pkg;

  // Step counter covering both write lists.
  localparam int STEP_W = 4;

  // Step positions the control decodes. Power-up occupies steps 0..9 and
  // power-down occupies steps 10..15.
  localparam logic [STEP_W-1:0] STEP_RATE     = 4'd0;
  localparam logic [STEP_W-1:0] STEP_DAC_ON   = 4'd7;
  localparam logic [STEP_W-1:0] STEP_RAMP_ON  = 4'd9;
  localparam logic [STEP_W-1:0] STEP_RAMP_OFF = 4'd10;
  localparam logic [STEP_W-1:0] STEP_LAST     = 4'd15;

  typedef enum logic [1:0] {
    WK_LOCK,
    WK_SETTLE,
    WK_RISE,
    WK_FALL
  } waitKind_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WRITE,
    SQ_WAIT,
    SQ_PLAY
  } seqState_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic      clrStep;
    logic      incStep;
    logic      jumpStop;
    logic      startWait;
    waitKind_e kind;
  } seqStrobe_t;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } regWrite_t;

  // Address/data issued at each step.
  function automatic regWrite_t stepWrite(input logic [STEP_W-1:0] idx);
    regWrite_t w;
    case (idx)
      4'd0:    w = '{addr: 8'h01, data: 8'hF4}; // sample rate
      4'd1:    w = '{addr: 8'h08, data: 8'hA5}; // headphone analog gain
      4'd2:    w = '{addr: 8'h18, data: 8'h0A}; // equalizer on
      4'd3:    w = '{addr: 8'h1A, data: 8'h28}; // left digital volume
      4'd4:    w = '{addr: 8'h1B, data: 8'h28}; // right digital volume
      4'd5:    w = '{addr: 8'h0B, data: 8'h01}; // left DAC-to-headphone path
      4'd6:    w = '{addr: 8'h0C, data: 8'h01}; // right DAC-to-headphone path
      4'd7:    w = '{addr: 8'h00, data: 8'hC1}; // DAC power-up
      4'd8:    w = '{addr: 8'h10, data: 8'h63}; // amplifiers on
      4'd9:    w = '{addr: 8'h10, data: 8'h67}; // common-voltage ramp up
      4'd10:   w = '{addr: 8'h10, data: 8'h63}; // common-voltage ramp down
      4'd11:   w = '{addr: 8'h10, data: 8'h00}; // amplifiers off
      4'd12:   w = '{addr: 8'h00, data: 8'h01}; // DAC power-down
      4'd13:   w = '{addr: 8'h18, data: 8'h02}; // equalizer off
      4'd14:   w = '{addr: 8'h0B, data: 8'h00}; // left path off
      default: w = '{addr: 8'h0C, data: 8'h00}; // right path off
    endcase
    return w;
  endfunction

endpackage

// File: rtl/hp_seq_ctrl.sv
module hp_seq_ctrl
  import hp_seq_pkg::*;
#(
  parameter bit PLL_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startCmd,
  input  logic              stopCmd,
  input  logic              wrAck,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              waitDone,
  output seqStrobe_t        strobe,
  output logic              wrReq,
  output logic              busy,
  output logic              playing,
  output logic              idle
);

  seqState_e stateQ, stateD;
  waitKind_e kindQ, kindD;
  logic      lockHere;

  // The lock wait follows the sample-rate write only in PLL mode.
  generate
    if (PLL_MODE) begin : g_lock
      assign lockHere = (stepIdx == STEP_RATE);
    end else begin : g_nolock
      assign lockHere = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    kindD  = kindQ;
    case (stateQ)
      SQ_IDLE: begin
        if (startCmd) begin
          strobe.clrStep = 1'b1;
          stateD         = SQ_WRITE;
        end
      end
      SQ_WRITE: begin
        if (wrAck) begin
          if (lockHere) begin
            strobe.startWait = 1'b1;
            strobe.kind      = WK_LOCK;
          end else if (stepIdx == STEP_DAC_ON) begin
            strobe.startWait = 1'b1;
            strobe.kind      = WK_SETTLE;
          end else if (stepIdx == STEP_RAMP_ON) begin
            strobe.startWait = 1'b1;
            strobe.kind      = WK_RISE;
          end else if (stepIdx == STEP_RAMP_OFF) begin
            strobe.startWait = 1'b1;
            strobe.kind      = WK_FALL;
          end else if (stepIdx == STEP_LAST) begin
            stateD = SQ_IDLE;
          end else begin
            strobe.incStep = 1'b1;
          end
          if (strobe.startWait) begin
            stateD = SQ_WAIT;
            kindD  = strobe.kind;
          end
        end
      end
      SQ_WAIT: begin
        // Only the rise wait may be cut short; the fall wait always runs out.
        if (kindQ == WK_RISE && stopCmd) begin
          strobe.jumpStop = 1'b1;
          stateD          = SQ_WRITE;
        end else if (waitDone) begin
          if (kindQ == WK_RISE) begin
            stateD = SQ_PLAY;
          end else begin
            strobe.incStep = 1'b1;
            stateD         = SQ_WRITE;
          end
        end
      end
      default: begin
        if (stopCmd) begin
          strobe.jumpStop = 1'b1;
          stateD          = SQ_WRITE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= SQ_IDLE;
      kindQ  <= WK_LOCK;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
    end
  end

  assign wrReq   = (stateQ == SQ_WRITE);
  assign busy    = (stateQ == SQ_WRITE) || (stateQ == SQ_WAIT);
  assign playing = (stateQ == SQ_PLAY);
  assign idle    = (stateQ == SQ_IDLE);

endmodule

// File: rtl/hp_seq_dpath.sv
module hp_seq_dpath
  import hp_seq_pkg::*;
#(
  parameter int PRESCALE     = 12000,
  parameter int LOCK_TICKS   = 10,
  parameter int SETTLE_TICKS = 20,
  parameter int RISE_TICKS   = 250,
  parameter int FALL_TICKS   = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  output logic [STEP_W-1:0] stepIdx,
  output logic              waitDone,
  output logic [7:0]        wrAddr,
  output logic [7:0]        wrData
);

  localparam int FALL2_TICKS = 2 * FALL_TICKS;
  localparam int MAX_A       = (LOCK_TICKS > SETTLE_TICKS) ? LOCK_TICKS : SETTLE_TICKS;
  localparam int MAX_B       = (RISE_TICKS > FALL2_TICKS) ? RISE_TICKS : FALL2_TICKS;
  localparam int MAX_TICKS   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W       = $clog2(MAX_TICKS + 1) + 1;

  logic [STEP_W-1:0] stepQ;
  logic [CNT_W-1:0]  tgtQ;
  logic [CNT_W-1:0]  cntQ;
  logic              tick;
  regWrite_t         curWrite;

  // Step pointer.
  always_ff @(posedge clk) begin
    if (rst || strobe.clrStep) begin
      stepQ <= '0;
    end else if (strobe.jumpStop) begin
      stepQ <= STEP_RAMP_OFF;
    end else if (strobe.incStep) begin
      stepQ <= stepQ + 1'b1;
    end
  end

  assign stepIdx  = stepQ;
  assign curWrite = stepWrite(stepQ);
  assign wrAddr   = curWrite.addr;
  assign wrData   = curWrite.data;

  // Prescaler: restarts with each wait so every wait has an exact length.
  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] preQ;
      assign tick = (preQ == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (rst || strobe.startWait || tick) begin
          preQ <= '0;
        end else begin
          preQ <= preQ + 1'b1;
        end
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // Wait length is latched when the wait starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      tgtQ <= '0;
    end else if (strobe.startWait) begin
      case (strobe.kind)
        WK_LOCK:   tgtQ <= CNT_W'(LOCK_TICKS);
        WK_SETTLE: tgtQ <= CNT_W'(SETTLE_TICKS);
        WK_RISE:   tgtQ <= CNT_W'(RISE_TICKS);
        default:   tgtQ <= CNT_W'(FALL2_TICKS);
      endcase
    end
  end

  // Tick counter; stops once it reaches the target.
  always_ff @(posedge clk) begin
    if (rst || strobe.startWait) begin
      cntQ <= '0;
    end else if (tick && !waitDone) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign waitDone = (cntQ == tgtQ);

endmodule

// File: rtl/hp_power_seq.sv
module hp_power_seq
  import hp_seq_pkg::*;
#(
  parameter bit PLL_MODE     = 1'b1,
  parameter int PRESCALE     = 12000,
  parameter int LOCK_TICKS   = 10,
  parameter int SETTLE_TICKS = 20,
  parameter int RISE_TICKS   = 250,
  parameter int FALL_TICKS   = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startCmd,
  input  logic       stopCmd,
  output logic       wrReq,
  output logic [7:0] wrAddr,
  output logic [7:0] wrData,
  input  logic       wrAck,
  output logic       busy,
  output logic       playing,
  output logic       idle
);

  seqStrobe_t        strobe;
  logic [STEP_W-1:0] stepIdx;
  logic              waitDone;

  hp_seq_ctrl #(
    .PLL_MODE(PLL_MODE)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startCmd (startCmd),
    .stopCmd  (stopCmd),
    .wrAck    (wrAck),
    .stepIdx  (stepIdx),
    .waitDone (waitDone),
    .strobe   (strobe),
    .wrReq    (wrReq),
    .busy     (busy),
    .playing  (playing),
    .idle     (idle)
  );

  hp_seq_dpath #(
    .PRESCALE     (PRESCALE),
    .LOCK_TICKS   (LOCK_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS),
    .RISE_TICKS   (RISE_TICKS),
    .FALL_TICKS   (FALL_TICKS)
  ) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .stepIdx  (stepIdx),
    .waitDone (waitDone),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: rtl/hp_seq_chk.sv
module hp_seq_chk #(
  parameter int PRESCALE   = 12000,
  parameter int FALL_TICKS = 250
) (
  input logic       clk,
  input logic       rst,
  input logic       startCmd,
  input logic       stopCmd,
  input logic       wrReq,
  input logic [7:0] wrAddr,
  input logic [7:0] wrData,
  input logic       wrAck,
  input logic       busy,
  input logic       playing,
  input logic       idle
);

  localparam int FALL_MIN = 2 * FALL_TICKS * PRESCALE;

  logic rampHigh;
  int   fallCnt;

  // Cycles since the ramp-down write was accepted, saturating at the minimum.
  always_ff @(posedge clk) begin
    if (rst) begin
      rampHigh <= 1'b0;
      fallCnt  <= 0;
    end else begin
      if (wrReq && wrAck && wrAddr == 8'h10) begin
        rampHigh <= (wrData == 8'h67);
      end
      if (wrReq && wrAck && wrAddr == 8'h10 && wrData == 8'h63 && rampHigh) begin
        fallCnt <= 0;
      end else if (fallCnt < FALL_MIN) begin
        fallCnt <= fallCnt + 1;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (idle && !wrReq && !busy && !playing));

  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wrReq && !wrAck) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  // R3
  quiet_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wrReq);

  // R11
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({idle, busy, playing}) == 1);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !startCmd) |=> idle);

  // R6
  play_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (playing && !stopCmd) |=> playing);

  // R8
  fall_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (wrReq && wrAddr == 8'h10 && wrData == 8'h00) |-> (fallCnt >= FALL_MIN));

  // R12
  idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(wrReq && wrAck && wrAddr == 8'h0C && wrData == 8'h00));

endmodule

bind hp_power_seq hp_seq_chk #(
  .PRESCALE   (PRESCALE),
  .FALL_TICKS (FALL_TICKS)
) chk_i (.*);

// File: tb/hp_power_seq_tb_top.sv
module hp_power_seq_tb_top;

  localparam int P      = 3;
  localparam int LOCK   = 2;
  localparam int SETTLE = 3;
  localparam int RISE   = 4;
  localparam int FALL   = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startCmd = 1'b0;
  logic       stopCmd = 1'b0;
  logic       wrAck = 1'b0;
  logic       wrReq, busy, playing, idle;
  logic [7:0] wrAddr, wrData;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ackLat = 1;
  int ackCnt = 0;
  int writesSeen = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hp_power_seq #(
    .PLL_MODE     (1'b1),
    .PRESCALE     (P),
    .LOCK_TICKS   (LOCK),
    .SETTLE_TICKS (SETTLE),
    .RISE_TICKS   (RISE),
    .FALL_TICKS   (FALL)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .startCmd (startCmd),
    .stopCmd  (stopCmd),
    .wrReq    (wrReq),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrAck    (wrAck),
    .busy     (busy),
    .playing  (playing),
    .idle     (idle)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  // mode: 0 idle, 1 write, 2 wait, 3 playing. Ops >= 0 are writes (addr<<8|data),
  // negative ops are waits: -1 lock, -2 settle, -3 rise, -4 fall.
  int         opQ[$];
  int         mode = 0;
  int         left = 0;
  int         kindM = 0;
  bit         stopping = 1'b0;
  bit         riseAbort = 1'b0;
  logic [7:0] eA = 8'h00;
  logic [7:0] eD = 8'h00;
  string      tag = "R1";

  function automatic int waitLen(input int k);
    case (k)
      -1:      return LOCK * P + 1;
      -2:      return SETTLE * P + 1;
      -3:      return RISE * P + 1;
      default: return 2 * FALL * P + 1;
    endcase
  endfunction

  task automatic advance();
    int op;
    if (opQ.size() == 0) begin
      mode = stopping ? 0 : 3;
      tag  = stopping ? "R12" : "R6";
    end else begin
      op = opQ.pop_front();
      if (op >= 0) begin
        mode = 1;
        eA   = op[15:8];
        eD   = op[7:0];
        tag  = stopping ? "R7" : "R2";
      end else begin
        mode  = 2;
        kindM = op;
        left  = waitLen(op);
        case (op)
          -1:      tag = "R4";
          -2:      tag = "R5";
          -3:      tag = "R6";
          default: tag = riseAbort ? "R9" : "R8";
        endcase
      end
    end
  endtask

  task automatic loadStart();
    opQ.delete();
    opQ.push_back('h01F4);
    opQ.push_back(-1);
    opQ.push_back('h08A5);
    opQ.push_back('h180A);
    opQ.push_back('h1A28);
    opQ.push_back('h1B28);
    opQ.push_back('h0B01);
    opQ.push_back('h0C01);
    opQ.push_back('h00C1);
    opQ.push_back(-2);
    opQ.push_back('h1063);
    opQ.push_back('h1067);
    opQ.push_back(-3);
    stopping  = 1'b0;
    riseAbort = 1'b0;
  endtask

  task automatic loadStop(input bit abort);
    opQ.delete();
    opQ.push_back('h1063);
    opQ.push_back(-4);
    opQ.push_back('h1000);
    opQ.push_back('h0001);
    opQ.push_back('h1802);
    opQ.push_back('h0B00);
    opQ.push_back('h0C00);
    stopping  = 1'b1;
    riseAbort = abort;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mode = 0;
      opQ.delete();
      tag = "R1";
    end else begin
      if (wrReq && wrAck) writesSeen++;
      case (mode)
        0: if (startCmd) begin loadStart(); advance(); end
        1: if (wrAck) advance();
        2: begin
          if (kindM == -3 && stopCmd) begin
            loadStop(1'b1);
            advance();
          end else begin
            left--;
            if (left == 0) advance();
          end
        end
        default: if (stopCmd) begin loadStop(1'b0); advance(); end
      endcase
    end
  end

  // Compare on every clock, half a cycle after the update edge.
  always @(negedge clk) begin
    if (cyc >= 2 && !rst && !finished) begin
      check(wrReq === (mode == 1), tag, "wrReq", wrReq, mode == 1);
      check(busy === (mode == 1 || mode == 2), "R11", "busy", busy, mode == 1 || mode == 2);
      check(playing === (mode == 3), "R6", "playing", playing, mode == 3);
      check(idle === (mode == 0), tag, "idle", idle, mode == 0);
      if (mode == 1) begin
        check(wrAddr === eA, tag, "wrAddr", wrAddr, eA);
        check(wrData === eD, tag, "wrData", wrData, eD);
      end
    end
  end

  // Write acknowledger with programmable latency.
  always @(negedge clk) begin
    if (rst || wrAck) begin
      wrAck  <= 1'b0;
      ackCnt <= 0;
    end else if (wrReq) begin
      if (ackCnt >= ackLat) wrAck <= 1'b1;
      else ackCnt <= ackCnt + 1;
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  task automatic pulseStart();
    @(negedge clk) startCmd = 1'b1;
    @(negedge clk) startCmd = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopCmd = 1'b1;
    @(negedge clk) stopCmd = 1'b0;
  endtask

  task automatic waitMode(input int m);
    while (mode != m) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(idle === 1'b1 && wrReq === 1'b0 && busy === 1'b0 && playing === 1'b0,
          "R1", "reset status", {idle, wrReq, busy, playing}, 4'b1000);
    rst = 1'b0;

    // R10: stop in idle is ignored
    pulseStop();
    @(negedge clk);
    check(idle === 1'b1 && wrReq === 1'b0, "R10", "stop in idle", {idle, wrReq}, 2'b10);

    // R2/R4/R5/R6: power-up with same-cycle acks; stray commands are ignored
    ackLat = 0;
    pulseStart();
    repeat (2) @(negedge clk);
    pulseStop();
    pulseStart();
    check(busy === 1'b1, "R10", "commands during power-up", busy, 1);
    waitMode(3);
    @(negedge clk);
    check(playing === 1'b1, "R6", "playing after rise", playing, 1);
    check(writesSeen == 10, "R2", "power-up write count", writesSeen, 10);

    // R10: start while playing is ignored
    pulseStart();
    @(negedge clk);
    check(playing === 1'b1 && wrReq === 1'b0, "R10", "start while playing",
          {playing, wrReq}, 2'b10);

    // R7/R8/R12: power-down with slow acks; a stop during the fall wait is ignored
    ackLat = 2;
    pulseStop();
    while (!(mode == 2 && kindM == -4)) @(negedge clk);
    pulseStop();
    waitMode(0);
    @(negedge clk);
    check(idle === 1'b1 && busy === 1'b0, "R12", "idle after power-down",
          {idle, busy}, 2'b10);
    check(writesSeen == 16, "R7", "power-down write count", writesSeen, 16);

    // R9: stop during the rise wait
    ackLat = 1;
    pulseStart();
    while (!(mode == 2 && kindM == -3)) @(negedge clk);
    repeat (2) @(negedge clk);
    pulseStop();
    waitMode(0);
    @(negedge clk);
    check(idle === 1'b1, "R9", "idle after aborted ramp", idle, 1);
    check(writesSeen == 32, "R9", "write count after abort", writesSeen, 32);

    // R1: reset in the middle of power-up
    pulseStart();
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(idle === 1'b1 && wrReq === 1'b0 && busy === 1'b0, "R1", "mid-run reset",
          {idle, wrReq, busy}, 3'b100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(idle === 1'b1, "R1", "idle after reset release", idle, 1);

    summary();
  end

endmodule